// File: doc/BRIEF.md
# External Bus Control and Timing Unit

This block holds one 8-bit bus control register and turns its fields into the behaviour seen at the memory interface. The fields set four things: the low time of the row strobe during a CAS-before-RAS DRAM refresh, the byte addressing mode used by every SRAM-type area, whether an external bus master may take the bus, and whether such a master may park the CPU in a halt state. One further field lets an active-low wait input stretch SRAM read and write cycles.

There are two reset inputs. A cold reset clears the register and all sequencing state. A hot reset clears only the sequencing state: it ends any refresh pulse in progress and empties the wait synchronizer, but it keeps the register contents. The wait input first passes through a synchronizer clocked on the rising edge. The result is then sampled on every falling edge of the bus clock. The register write port takes one cycle; the read port is combinational.

Top module: `ext_bus_ctl`

## Requirements
- R1: A write (regWrEn high at a rising edge) stores regWrData bits 6:5 as the refresh width, bit 3 as the SRAM byte mode, bit 2 as the external-master enable, bit 1 as the power-down enable and bit 0 as the wait enable. regRdData returns these values at the same bit positions.
- R2: Bits 7 and 4 of regRdData always read 0, whatever value was written to them.
- R3: While coldRstN is low, every register field is cleared to 0 (regRdData = 0x00), rasN is high and waitExtend is low.
- R4: A low pulse on hotRstN leaves regRdData unchanged and ends any refresh pulse in progress, so rasN returns high.
- R5: A one-cycle refreshTrig while idle drives rasN low from the next rising edge for exactly 2 + width cycles. A width field of 0 gives 2 cycles, 1 gives 3, 2 gives 4 and 3 gives 5.
- R6: refreshTrig is ignored while a refresh pulse is in progress. The pulse length does not change, and no second pulse follows.
- R7: grantEn is high exactly when busReqN is low and the external-master field (bit 2) is 1. Otherwise the request is ignored.
- R8: haltReq is high exactly when busReqN is low and the power-down field (bit 1) is 1.
- R9: With the wait enable field (bit 0) at 1 and sramCycle high, a low level on waitN drives waitExtend high within three clock cycles. waitExtend stays high until a falling-edge sample reads waitN high.
- R10: With the wait enable field at 0, waitExtend stays low whatever waitN does.
- R11: byteSelMode follows field bit 3: 1 selects byte-select-line mode and 0 selects A0 addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| coldRstN | input | 1 | Cold reset, active low, asynchronous; clears register and state |
| hotRstN | input | 1 | Hot reset, active low, asynchronous; clears state only |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| refreshTrig | input | 1 | One-cycle refresh request |
| rasN | output | 1 | Refresh row strobe, active low |
| sramCycle | input | 1 | High while an SRAM read/write cycle runs |
| waitN | input | 1 | Wait request, active low, asynchronous |
| waitExtend | output | 1 | Insert a wait cycle |
| busReqN | input | 1 | External bus request, active low |
| grantEn | output | 1 | Bus request accepted |
| haltReq | output | 1 | CPU halt request |
| byteSelMode | output | 1 | SRAM addressing mode select |

## Verification
A corrupted register field shows up at regRdData at once. It also shows on the combinational outputs grantEn, haltReq and byteSelMode in the same cycle that busReqN is driven. A wrong pulse counter or a stuck sequencer state shows as a rasN pulse of the wrong length, at the latest five cycles after the trigger, or as a second pulse or an early release when the trigger is repeated. A wrong synchronizer or sampling phase shows as a waitExtend response that comes later than three cycles, or that is released while waitN is still low.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
  localparam int REG_W       = 8;
  localparam int BIT_WAIT    = 0;
  localparam int BIT_PWRDN   = 1;
  localparam int BIT_MASTER  = 2;
  localparam int BIT_BYTESEL = 3;
  localparam int BIT_WIDTH_LO = 5;
  localparam int WIDTH_FLD_W = 2;

  typedef struct packed {
    logic [WIDTH_FLD_W-1:0] rasWidth;
    logic                   byteSel;
    logic                   extMaster;
    logic                   pwrDownEn;
    logic                   waitEn;
  } busCfg_t;

  typedef struct packed {
    logic regLoad;
    logic rasStart;
    logic rasStep;
    logic rasClear;
  } dpStrobe_t;
endpackage

// File: rtl/busctl_dp.sv
module busctl_dp
  import busctl_pkg::*;
#(
  parameter int BASE_PULSE  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int MAX_PULSE  = BASE_PULSE + (1 << WIDTH_FLD_W) - 1,
  localparam int CNT_W      = $clog2(MAX_PULSE + 1)
) (
  input  logic             clk,
  input  logic             coldRstN,
  input  logic             stateRstN,
  input  dpStrobe_t        strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic             waitN,
  output busCfg_t          cfg,
  output logic             rasLast,
  output logic             waitLowSample
);
  logic [CNT_W-1:0] rasCnt;
  logic [SYNC_STAGES-1:0] syncChain;

  // Configuration register: cleared only by a cold start
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      cfg <= '0;
    end else if (strobe.regLoad) begin
      cfg.rasWidth  <= wrData[BIT_WIDTH_LO +: WIDTH_FLD_W];
      cfg.byteSel   <= wrData[BIT_BYTESEL];
      cfg.extMaster <= wrData[BIT_MASTER];
      cfg.pwrDownEn <= wrData[BIT_PWRDN];
      cfg.waitEn    <= wrData[BIT_WAIT];
    end
  end

  // Pulse length counter, loaded with (length - 1)
  always_ff @(posedge clk or negedge stateRstN) begin
    if (!stateRstN) begin
      rasCnt <= '0;
    end else if (strobe.rasClear) begin
      rasCnt <= '0;
    end else if (strobe.rasStart) begin
      rasCnt <= CNT_W'(BASE_PULSE - 1) + CNT_W'(cfg.rasWidth);
    end else if (strobe.rasStep && rasCnt != '0) begin
      rasCnt <= rasCnt - 1'b1;
    end
  end

  assign rasLast = (rasCnt == '0);

  // Wait input synchronizer, rising-edge stages
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge stateRstN) begin
        if (!stateRstN) syncChain[s] <= 1'b1;
        else if (s == 0) syncChain[s] <= waitN;
        else             syncChain[s] <= syncChain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // Falling-edge sample of the synchronized wait level
  always_ff @(negedge clk or negedge stateRstN) begin
    if (!stateRstN) waitLowSample <= 1'b0;
    else            waitLowSample <= cfg.waitEn & ~syncChain[SYNC_STAGES-1];
  end

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!stateRstN)
    rasCnt <= CNT_W'(MAX_PULSE - 1));
  p_wait_sample_off_r10: assert property (@(posedge clk) disable iff (!stateRstN)
    (!cfg.waitEn && $past(!cfg.waitEn)) |-> !waitLowSample);
endmodule

// File: rtl/busctl_ctrl.sv
module busctl_ctrl
  import busctl_pkg::*;
(
  input  logic      clk,
  input  logic      stateRstN,
  input  logic      regWrEn,
  input  logic      refreshTrig,
  input  logic      rasLast,
  input  logic      sramCycle,
  input  logic      waitLowSample,
  input  logic      busReqN,
  input  busCfg_t   cfg,
  output dpStrobe_t strobe,
  output logic      rasN,
  output logic      waitExtend,
  output logic      grantEn,
  output logic      haltReq
);
  typedef enum logic {ST_IDLE, ST_PULSE} rasState_t;
  rasState_t state, stateNext;

  always_comb begin
    stateNext       = state;
    strobe          = '0;
    strobe.regLoad  = regWrEn;
    unique case (state)
      ST_IDLE: if (refreshTrig) begin
        strobe.rasStart = 1'b1;
        stateNext       = ST_PULSE;
      end
      ST_PULSE: if (rasLast) begin
        strobe.rasClear = 1'b1;
        stateNext       = ST_IDLE;
      end else begin
        strobe.rasStep  = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge stateRstN) begin
    if (!stateRstN) state <= ST_IDLE;
    else            state <= stateNext;
  end

  assign rasN       = (state != ST_PULSE);
  assign waitExtend = cfg.waitEn & sramCycle & waitLowSample;
  assign grantEn    = cfg.extMaster & ~busReqN;
  assign haltReq    = cfg.pwrDownEn & ~busReqN;

  p_trig_starts_r5: assert property (@(posedge clk) disable iff (!stateRstN)
    (rasN && refreshTrig) |=> !rasN);
  p_pulse_holds_r6: assert property (@(posedge clk) disable iff (!stateRstN)
    (!rasN && !rasLast) |=> !rasN);
  p_pulse_ends_r5: assert property (@(posedge clk) disable iff (!stateRstN)
    (!rasN && rasLast) |=> rasN);
  p_grant_ignored_r7: assert property (@(posedge clk) disable iff (!stateRstN)
    (busReqN || !cfg.extMaster) |-> !grantEn);
  p_halt_ignored_r8: assert property (@(posedge clk) disable iff (!stateRstN)
    (busReqN || !cfg.pwrDownEn) |-> !haltReq);
endmodule

// File: rtl/ext_bus_ctl.sv
module ext_bus_ctl
  import busctl_pkg::*;
#(
  parameter int BASE_PULSE  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             coldRstN,
  input  logic             hotRstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             refreshTrig,
  output logic             rasN,
  input  logic             sramCycle,
  input  logic             waitN,
  output logic             waitExtend,
  input  logic             busReqN,
  output logic             grantEn,
  output logic             haltReq,
  output logic             byteSelMode
);
  busCfg_t   cfg;
  dpStrobe_t strobe;
  logic      rasLast;
  logic      waitLowSample;
  logic      stateRstN;

  assign stateRstN = coldRstN & hotRstN;

  busctl_dp #(.BASE_PULSE(BASE_PULSE), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .coldRstN(coldRstN), .stateRstN(stateRstN), .strobe(strobe),
    .wrData(regWrData), .waitN(waitN), .cfg(cfg), .rasLast(rasLast),
    .waitLowSample(waitLowSample)
  );

  busctl_ctrl ctrl_i (
    .clk(clk), .stateRstN(stateRstN), .regWrEn(regWrEn),
    .refreshTrig(refreshTrig), .rasLast(rasLast), .sramCycle(sramCycle),
    .waitLowSample(waitLowSample), .busReqN(busReqN), .cfg(cfg),
    .strobe(strobe), .rasN(rasN), .waitExtend(waitExtend),
    .grantEn(grantEn), .haltReq(haltReq)
  );

  always_comb begin
    regRdData = '0;
    regRdData[BIT_WIDTH_LO +: WIDTH_FLD_W] = cfg.rasWidth;
    regRdData[BIT_BYTESEL] = cfg.byteSel;
    regRdData[BIT_MASTER]  = cfg.extMaster;
    regRdData[BIT_PWRDN]   = cfg.pwrDownEn;
    regRdData[BIT_WAIT]    = cfg.waitEn;
  end

  assign byteSelMode = cfg.byteSel;

  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!coldRstN)
    (regRdData[7] == 1'b0) && (regRdData[4] == 1'b0));
  p_hot_keeps_r4: assert property (@(posedge clk) disable iff (!coldRstN)
    (!hotRstN && !regWrEn) |=> $stable(regRdData));
endmodule

// File: tb/ext_bus_ctl_tb_top.sv
module ext_bus_ctl_tb_top;
  logic clk = 1'b0;
  logic coldRstN = 1'b0, hotRstN = 1'b1;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic refreshTrig = 1'b0, rasN;
  logic sramCycle = 1'b0, waitN = 1'b1, waitExtend;
  logic busReqN = 1'b1, grantEn, haltReq, byteSelMode;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_bus_ctl dut_i (.*);

  typedef struct packed {
    logic [7:0] wr;
    logic       reqN;
    logic [7:0] expRd;
    logic       expGrant;
    logic       expHalt;
    logic       expByteSel;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h04, 1'b0, 8'h04, 1'b1, 1'b0, 1'b0},
    '{8'h04, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0},
    '{8'h02, 1'b0, 8'h02, 1'b0, 1'b1, 1'b0},
    '{8'h06, 1'b0, 8'h06, 1'b1, 1'b1, 1'b0},
    '{8'h08, 1'b0, 8'h08, 1'b0, 1'b0, 1'b1},
    '{8'hFF, 1'b0, 8'h6F, 1'b1, 1'b1, 1'b1},
    '{8'h90, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    '{8'h41, 1'b1, 8'h41, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d; tick(1); regWrEn = 1'b0;
  endtask

  task automatic measure(input logic [7:0] cfgVal, input bit retrig, output int len, output logic after);
    wr(cfgVal);
    refreshTrig = 1'b1; tick(1); refreshTrig = 1'b0;
    len = 0;
    while (!rasN && len < 20) begin
      len++;
      if (retrig && len == 2) refreshTrig = 1'b1;
      tick(1);
      refreshTrig = 1'b0;
    end
    tick(1);
    after = rasN;
  endtask

  initial begin
    int len;
    logic after;
    #3;
    check("R3 reset read", regRdData, 8'h00);
    check("R3 reset ras", {7'd0, rasN}, 8'h01);
    check("R3 reset wait", {7'd0, waitExtend}, 8'h00);
    tick(2); coldRstN = 1'b1; tick(1);

    // R1 R2 R7 R8 R11: vector walk
    foreach (VEC[i]) begin
      wr(VEC[i].wr);
      busReqN = VEC[i].reqN; #1;
      check("R1/R2 readback", regRdData, VEC[i].expRd);
      check("R7 grant", {7'd0, grantEn}, {7'd0, VEC[i].expGrant});
      check("R8 halt", {7'd0, haltReq}, {7'd0, VEC[i].expHalt});
      check("R11 bytesel", {7'd0, byteSelMode}, {7'd0, VEC[i].expByteSel});
      busReqN = 1'b1;
    end

    // R5 pulse widths
    for (int w = 0; w < 4; w++) begin
      measure({1'b0, 2'(w), 5'b0}, 0, len, after);
      check("R5 pulse width", 8'(len), 8'(w + 2));
    end

    // R6 retrigger ignored
    measure(8'h60, 1, len, after);
    check("R6 retrig width", 8'(len), 8'd5);
    check("R6 no second pulse", {7'd0, after}, 8'h01);

    // R9 wait extension
    wr(8'h01); sramCycle = 1'b1; waitN = 1'b0;
    tick(3);
    check("R9 wait asserted", {7'd0, waitExtend}, 8'h01);
    tick(2);
    check("R9 wait held", {7'd0, waitExtend}, 8'h01);
    waitN = 1'b1; tick(3);
    check("R9 wait released", {7'd0, waitExtend}, 8'h00);

    // R10 wait disabled
    wr(8'h00); waitN = 1'b0; tick(4);
    check("R10 wait ignored", {7'd0, waitExtend}, 8'h00);
    waitN = 1'b1; sramCycle = 1'b0;

    // R4 hot reset keeps register, ends pulse
    wr(8'h6F);
    refreshTrig = 1'b1; tick(1); refreshTrig = 1'b0; tick(1);
    check("R4 pulse running", {7'd0, rasN}, 8'h00);
    hotRstN = 1'b0; #1;
    check("R4 ras released", {7'd0, rasN}, 8'h01);
    tick(1); hotRstN = 1'b1; tick(1);
    check("R4 register kept", regRdData, 8'h6F);

    // R3 cold reset clears
    coldRstN = 1'b0; #1;
    check("R3 cold clear", regRdData, 8'h00);
    tick(1); coldRstN = 1'b1; tick(1);
    check("R3 cold clear after", regRdData, 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(8 * 100000);
        nRun++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule